// File: doc/BRIEF.md
# Lockable Watchdog Timer Controller

This block is a watchdog timer whose 5-bit mode word is write-only. Software may write the word only during a short window, and the word then stays fixed until the next reset or recovery event. After power-on reset, after a watchdog reset, or after any stop-mode recovery, the window opens on the first instruction strobe. It stays open for 60 clock edges and then shuts. Writes made outside this window are dropped. The counter advances on tick pulses from one of two sources: an internal RC tick or the crystal tick. It fires when the count reaches one of four tap-selected periods. A refresh strobe restarts the count from zero.

The mode word holds four fields. Bits 1:0 select the tap, bit 2 keeps the count running in halt, bit 3 keeps it running in stop, and bit 4 selects the tick source. The halt and stop status inputs decide whether the counter runs or holds. A timeout is reported on one of two flags, set by the mode the core is in at the time. Outside stop mode, a timeout is a full watchdog reset, which also restores the mode word to its defaults. Inside stop mode, a timeout is an internal wakeup, and the mode word is kept.

The window logic is a three-state machine. WIN_WAIT moves to WIN_OPEN on the first instruction strobe. WIN_OPEN moves to WIN_SHUT after 60 edges. Any recovery event sends the machine from any state back to WIN_WAIT. The reporting logic is a second three-state machine. From REC_IDLE, an expiry goes to REC_RESET when stop is low, or to REC_WAKE when stop is high. Both of those states return to REC_IDLE on the next edge.

Top module: `wdt_lockable`

## Requirements
- R1: After power-on reset, the mode word is tap 01, halt-run 1, stop-run 1 and tick source RC (bit 4 = 0). The window is closed (WIN_WAIT), and both timeout flags are low.
- R2: The window opens on the edge that samples the first `first_instr_i` after a reset or recovery event. The mode word accepts writes on each of the following 60 edges, and `mode_open_o` is high exactly during those 60 cycles.
- R3: A mode write is ignored before the first instruction strobe. It is also ignored on any edge after the 60-edge window has closed.
- R4: Bits 1:0 select the timeout period in ticks: 00 gives 256, 01 gives 512, 10 gives 1024 and 11 gives 4096.
- R5: Bit 4 selects the tick source. With 0, the counter advances on `rc_tick_i`. With 1, it advances on `xtal_tick_i`.
- R6: A refresh clears the count to zero and takes priority over a tick on the same edge. The next timeout then comes after a full period.
- R7: When the count reaches the selected period, the counter restarts from zero. One cycle later, exactly one flag pulses for one cycle. Outside stop mode, `wdt_reset_o` pulses. The edge after that pulse restores the R1 defaults and sends the window to WIN_WAIT.
- R8: While halt is high and stop is low, bit 2 = 1 lets the count continue. With bit 2 = 0, the count holds and no timeout occurs.
- R9: While stop is high, bit 3 = 0 makes the count hold. With bit 3 = 1, a timeout pulses `stop_wake_o` instead of `wdt_reset_o`. The mode word is kept, and the window returns to WIN_WAIT.
- R10: A pulse on `stop_recover_i` sends the window to WIN_WAIT and leaves the mode word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Power-on reset, active low |
| first_instr_i | input | 1 | Instruction strobe; the first one after an event opens the window |
| mode_wr_i | input | 1 | Mode word write strobe |
| mode_data_i | input | 5 | Mode word write data |
| refresh_i | input | 1 | Watchdog refresh strobe |
| rc_tick_i | input | 1 | Internal RC oscillator tick |
| xtal_tick_i | input | 1 | Crystal clock tick |
| halt_mode_i | input | 1 | Core is in halt mode |
| stop_mode_i | input | 1 | Core is in stop mode |
| stop_recover_i | input | 1 | Stop recovery from a source outside the watchdog |
| mode_open_o | output | 1 | High while mode writes are accepted |
| wdt_reset_o | output | 1 | One-cycle watchdog reset pulse |
| stop_wake_o | output | 1 | One-cycle stop-mode wakeup pulse |

## Verification
Each tap is run from a refresh with only one tick source active. This separates the four periods from each other and shows which source is driving the count. Writes are placed one edge before the window opens, on its last accepted edge and one edge past its end, which pins the 60-edge boundary on both sides. Halt and stop are held during counting with their run bits cleared. The resulting delay in the expected timeout shows that the count was held, and a timeout in stop must appear on the wake flag. A retained mode word is exposed by a second timeout that can only come from the written source and tap.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;

    typedef enum logic [1:0] {
        WIN_WAIT,
        WIN_OPEN,
        WIN_SHUT
    } win_state_e;

    typedef enum logic [1:0] {
        REC_IDLE,
        REC_RESET,
        REC_WAKE
    } rec_state_e;

    // bit 4 tick source, bit 3 stop run, bit 2 halt run, bits 1:0 tap
    typedef struct packed {
        logic       clk_xtal;
        logic       stop_run;
        logic       halt_run;
        logic [1:0] tap;
    } wdt_mode_t;

    localparam wdt_mode_t MODE_DEFAULT = '{clk_xtal: 1'b0, stop_run: 1'b1,
                                           halt_run: 1'b1, tap: 2'b01};

endpackage

// File: rtl/wdt_mode_window.sv
module wdt_mode_window
    import wdt_lock_pkg::*;
#(
    parameter int WIN_CYCLES = 60
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      first_instr_i,
    input  logic      recover_i,
    input  logic      full_reset_i,
    input  logic      wr_en_i,
    input  logic [4:0] wr_data_i,
    output wdt_mode_t mode_o,
    output logic      open_o
);
    localparam int WIN_W = $clog2(WIN_CYCLES);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

    win_state_e       state_q, state_d;
    logic [WIN_W-1:0] win_cnt_q;
    wdt_mode_t        mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WIN_WAIT;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_WAIT: if (first_instr_i) state_d = WIN_OPEN;
            WIN_OPEN: if (win_cnt_q == WIN_LAST) state_d = WIN_SHUT;
            WIN_SHUT: state_d = WIN_SHUT;
            default:  state_d = WIN_WAIT;
        endcase
        if (recover_i) state_d = WIN_WAIT;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 win_cnt_q <= '0;
        else if (state_q != WIN_OPEN) win_cnt_q <= '0;
        else                         win_cnt_q <= win_cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            mode_q <= MODE_DEFAULT;
        else if (full_reset_i)
            mode_q <= MODE_DEFAULT;
        else if (state_q == WIN_OPEN && wr_en_i && !recover_i)
            mode_q <= wdt_mode_t'(wr_data_i);
    end

    always_comb begin
        open_o = (state_q == WIN_OPEN);
        mode_o = mode_q;
    end
endmodule

// File: rtl/wdt_period_counter.sv
module wdt_period_counter #(
    parameter  int TAP_BASE_LOG2 = 8,
    localparam int CNT_W         = TAP_BASE_LOG2 + 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             refresh_i,
    input  logic [1:0]       tap_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int N_TAPS = 4;

    logic [CNT_W-1:0] last_tbl [N_TAPS];
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int SHIFT = (g == N_TAPS - 1) ? 4 : g;
        assign last_tbl[g] = (CNT_W'(1) << (TAP_BASE_LOG2 + SHIFT)) - 1'b1;
    end

    assign step     = tick_i && run_i && !refresh_i;
    assign expire_o = step && (cnt_q == last_tbl[tap_i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (refresh_i) cnt_q <= '0;
        else if (expire_o)  cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/wdt_recovery_fsm.sv
module wdt_recovery_fsm
    import wdt_lock_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic in_stop_i,
    output logic wdt_reset_o,
    output logic stop_wake_o
);
    rec_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= REC_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = REC_IDLE;
        unique case (state_q)
            REC_IDLE, REC_RESET, REC_WAKE:
                if (expire_i) state_d = in_stop_i ? REC_WAKE : REC_RESET;
            default: state_d = REC_IDLE;
        endcase
    end

    always_comb begin
        wdt_reset_o = 1'b0;
        stop_wake_o = 1'b0;
        unique case (state_q)
            REC_IDLE:  ;
            REC_RESET: wdt_reset_o = 1'b1;
            REC_WAKE:  stop_wake_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
    import wdt_lock_pkg::*;
#(
    parameter int TAP_BASE_LOG2 = 8,
    parameter int WIN_CYCLES    = 60
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       first_instr_i,
    input  logic       mode_wr_i,
    input  logic [4:0] mode_data_i,
    input  logic       refresh_i,
    input  logic       rc_tick_i,
    input  logic       xtal_tick_i,
    input  logic       halt_mode_i,
    input  logic       stop_mode_i,
    input  logic       stop_recover_i,
    output logic       mode_open_o,
    output logic       wdt_reset_o,
    output logic       stop_wake_o
);
    localparam int CNT_W = TAP_BASE_LOG2 + 4;

    wdt_mode_t        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick, run, expire, recover_any;

    assign recover_any = wdt_reset_o || stop_wake_o || stop_recover_i;
    assign tick        = mode_q.clk_xtal ? xtal_tick_i : rc_tick_i;
    assign run         = stop_mode_i ? mode_q.stop_run
                       : (halt_mode_i ? mode_q.halt_run : 1'b1);

    wdt_mode_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .first_instr_i(first_instr_i),
        .recover_i    (recover_any),
        .full_reset_i (wdt_reset_o),
        .wr_en_i      (mode_wr_i),
        .wr_data_i    (mode_data_i),
        .mode_o       (mode_q),
        .open_o       (mode_open_o)
    );

    wdt_period_counter #(.TAP_BASE_LOG2(TAP_BASE_LOG2)) i_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .run_i    (run),
        .refresh_i(refresh_i),
        .tap_i    (mode_q.tap),
        .expire_o (expire),
        .count_o  (cnt_q)
    );

    wdt_recovery_fsm i_recovery (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .expire_i   (expire),
        .in_stop_i  (stop_mode_i),
        .wdt_reset_o(wdt_reset_o),
        .stop_wake_o(stop_wake_o)
    );
endmodule

// File: rtl/wdt_lockable_chk.sv
module wdt_lockable_chk
    import wdt_lock_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             refresh_i,
    input logic             halt_mode_i,
    input logic             stop_mode_i,
    input logic             stop_recover_i,
    input logic             mode_open_o,
    input logic             wdt_reset_o,
    input logic             stop_wake_o,
    input wdt_mode_t        mode_q,
    input logic [CNT_W-1:0] cnt_q
);
    assert_one_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wdt_reset_o && stop_wake_o));

    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_reset_o |=> !wdt_reset_o);

    assert_reset_outside_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_reset_o |-> !$past(stop_mode_i));

    assert_defaults_restored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_reset_o |=> (mode_q == MODE_DEFAULT && !mode_open_o));

    assert_wake_in_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_wake_o |-> $past(stop_mode_i));

    assert_refresh_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_i |=> (cnt_q == '0));

    assert_halt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_mode_i && !stop_mode_i && !mode_q.halt_run && !refresh_i) |=> $stable(cnt_q));

    assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_mode_i && !mode_q.stop_run && !refresh_i) |=> $stable(cnt_q));

    assert_recover_closes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_recover_i |=> !mode_open_o);
endmodule

bind wdt_lockable wdt_lockable_chk #(.CNT_W(CNT_W)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .refresh_i     (refresh_i),
    .halt_mode_i   (halt_mode_i),
    .stop_mode_i   (stop_mode_i),
    .stop_recover_i(stop_recover_i),
    .mode_open_o   (mode_open_o),
    .wdt_reset_o   (wdt_reset_o),
    .stop_wake_o   (stop_wake_o),
    .mode_q        (mode_q),
    .cnt_q         (cnt_q)
);

// File: tb/test_wdt_lockable.sv
module test_wdt_lockable;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       first_instr = 1'b0, mode_wr = 1'b0, refresh = 1'b0;
    logic [4:0] mode_data = '0;
    logic       rc_tick = 1'b0, xtal_tick = 1'b0;
    logic       halt_mode = 1'b0, stop_mode = 1'b0, stop_recover = 1'b0;
    logic       mode_open, wdt_reset, stop_wake;

    typedef struct { bit wake; int at; string req; } evt_t;
    evt_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0, n_fails = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_lockable i_wdt_lockable (
        .clk_i(clk), .rst_ni(rst_n), .first_instr_i(first_instr),
        .mode_wr_i(mode_wr), .mode_data_i(mode_data), .refresh_i(refresh),
        .rc_tick_i(rc_tick), .xtal_tick_i(xtal_tick), .halt_mode_i(halt_mode),
        .stop_mode_i(stop_mode), .stop_recover_i(stop_recover),
        .mode_open_o(mode_open), .wdt_reset_o(wdt_reset), .stop_wake_o(stop_wake)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a timeout flag pulses
    always @(negedge clk) begin
        if (rst_n && (wdt_reset || stop_wake)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected timeout at cycle", cyc, -1);
            end else begin
                evt_t e;
                e = exp_q.pop_front();
                check(e.at == cyc, e.req, "timeout cycle", cyc, e.at);
                check(stop_wake == e.wake, e.req, "wake flag", int'(stop_wake), int'(e.wake));
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_evt(input bit wake, input int at, input string req);
        evt_t e;
        e.wake = wake; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic do_refresh(output int e0);
        refresh = 1'b1; step(); refresh = 1'b0; e0 = cyc;
    endtask

    task automatic strobe();
        first_instr = 1'b1; step(); first_instr = 1'b0;
    endtask

    task automatic write_mode(input logic [4:0] d);
        mode_wr = 1'b1; mode_data = d; step(); mode_wr = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) step();
        step(2);
    endtask

    initial begin
        int e0;
        step(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        check(mode_open == 1'b0, "R1", "window after reset", int'(mode_open), 0);
        check(wdt_reset == 1'b0, "R1", "reset flag idle", int'(wdt_reset), 0);
        check(stop_wake == 1'b0, "R1", "wake flag idle", int'(stop_wake), 0);

        // R3: write before first instruction ignored; R1 default tap 512 on RC
        write_mode(5'b11100);
        strobe();
        check(mode_open == 1'b1, "R2", "window open after strobe", int'(mode_open), 1);
        rc_tick = 1'b1; xtal_tick = 1'b1;
        do_refresh(e0);
        expect_evt(1'b0, e0 + 512, "R3");
        wait_until(e0 + 512);
        rc_tick = 1'b0; xtal_tick = 1'b0;
        check(mode_open == 1'b0, "R7", "window waits after wdt reset", int'(mode_open), 0);

        // R2: last accepted edge; R4 tap 00, R5 crystal source, R6 re-refresh
        strobe();
        step(59);
        check(mode_open == 1'b1, "R2", "window still open at edge 59", int'(mode_open), 1);
        write_mode(5'b11100);
        check(mode_open == 1'b0, "R2", "window shut after 60 edges", int'(mode_open), 0);
        xtal_tick = 1'b1;
        do_refresh(e0);
        step(200);
        do_refresh(e0);
        expect_evt(1'b0, e0 + 256, "R6");
        wait_until(e0 + 256);
        xtal_tick = 1'b0;

        // R3: write one edge past the window is dropped
        strobe();
        step(60);
        write_mode(5'b11100);
        rc_tick = 1'b1; xtal_tick = 1'b1;
        do_refresh(e0);
        expect_evt(1'b0, e0 + 512, "R3");
        wait_until(e0 + 512);
        rc_tick = 1'b0; xtal_tick = 1'b0;

        // R4: tap 10 gives 1024
        strobe();
        write_mode(5'b11110);
        xtal_tick = 1'b1;
        do_refresh(e0);
        expect_evt(1'b0, e0 + 1024, "R4");
        wait_until(e0 + 1024);
        xtal_tick = 1'b0;

        // R4 tap 11 = 4096; R8 halt hold; R9 stop hold
        strobe();
        write_mode(5'b10011);
        xtal_tick = 1'b1;
        do_refresh(e0);
        step(100);
        halt_mode = 1'b1; step(300); halt_mode = 1'b0;
        step(100);
        stop_mode = 1'b1; step(200); stop_mode = 1'b0;
        expect_evt(1'b0, e0 + 4096 + 500, "R8");
        wait_until(e0 + 4596);
        xtal_tick = 1'b0;

        // R9: timeout in stop is a wakeup; mode kept
        strobe();
        write_mode(5'b11100);
        step(61);
        check(mode_open == 1'b0, "R9", "window shut before stop", int'(mode_open), 0);
        stop_mode = 1'b1;
        xtal_tick = 1'b1;
        do_refresh(e0);
        expect_evt(1'b1, e0 + 256, "R9");
        expect_evt(1'b0, e0 + 512, "R9");
        while (cyc < e0 + 256) step();
        stop_mode = 1'b0;
        step();
        check(mode_open == 1'b0, "R9", "window waits after wake", int'(mode_open), 0);
        strobe();
        check(mode_open == 1'b1, "R9", "window reopens after wake", int'(mode_open), 1);
        wait_until(e0 + 512);
        xtal_tick = 1'b0;

        // R10: outside stop recovery reopens window, mode kept; R8 halt runs
        strobe();
        write_mode(5'b11000);
        step(61);
        stop_recover = 1'b1; step(); stop_recover = 1'b0;
        check(mode_open == 1'b0, "R10", "window waits after recovery", int'(mode_open), 0);
        strobe();
        check(mode_open == 1'b1, "R10", "window reopens after recovery", int'(mode_open), 1);
        write_mode(5'b11100);
        xtal_tick = 1'b1;
        halt_mode = 1'b1;
        do_refresh(e0);
        expect_evt(1'b0, e0 + 256, "R8");
        wait_until(e0 + 256);
        halt_mode = 1'b0;
        xtal_tick = 1'b0;

        step(5);
        check(exp_q.size() == 0, "R7", "timeouts still pending", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung at cycle %0d expected end", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule